// File: doc/BRIEF.md
# Register-Mapped Interrupt Controller with Critical Vectoring

This block collects 32 interrupt sources into a single pending-status register and drives two request lines toward a processor: a normal line and a critical line. Each source is programmed as level-sensitive or edge-sensitive. An enable mask gates the status bits. A critical-select mask then sends each enabled source to one of the two lines. Software reaches the controller through a small register bus. The bus has an address, a write strobe and write data, and its read data is combinational. The nine registers sit in a window that starts at a parameterised base address.

When a critical source is pending, an optional vector unit builds a handler address. It takes a base from a configuration register and adds a 512-byte stride times the rank of the first pending critical bit. One configuration bit picks whether the scan starts from the low or the high end of the status word. The polarity register is stored and can be read back, but it has no effect on the inputs. Both request lines and the vector are registered. They change on the same clock edge as the state that causes them.

Top module: `crit_intc`

## Requirements
- R1: Input line n sets or clears status bit 31−n. Reading the status register therefore shows source 0 in bit 31.
- R2: Register offsets from the base are fixed: 0 status with write-one-to-clear, 1 status-set, 2 enable, 3 critical-select, 4 polarity, 5 trigger, 6 masked status, 7 vector, 8 vector configuration. Addresses outside this window read as 0.
- R3: A source whose trigger bit is 1 is edge-sensitive. While its input is sampled high, its status bit is set on every clock. A low input leaves the bit unchanged.
- R4: A source whose trigger bit is 0 is level-sensitive. When its sampled input changes, both its status bit and its internal level bit take the new input value.
- R5: A write to offset 0 clears the status bits written as 1 and then ORs the internal level vector back in, so an active level source stays pending. An edge input that is high in the same cycle as the clear wins.
- R6: The normal line is high when status & enable & ~critical-select is nonzero. The critical line is high when status & enable & critical-select is nonzero. Both update on the clock edge that changes their inputs.
- R7: Offsets 0 and 1 both read back status. Offset 6 reads status & enable. Writes to offsets 6 and 7 have no effect. The polarity register reads back what was written.
- R8: A write to offset 8 stores the data with bit 1 forced to 0. With the vector unit disabled by parameter, offsets 7 and 8 read as 0.
- R9: While a critical request is pending, the vector equals (configuration & ~3) + k×512. With configuration bit 0 at 0, k is the index of the lowest pending critical bit. With bit 0 at 1, k is 31 minus the index of the highest pending critical bit. With no critical request pending, the vector is 0.
- R10: Reset clears every register and both request lines to 0.
- R11: A write to offset 1 ORs the data into status. A bit set this way stays set until it is cleared through offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt source lines, index n maps to status bit 31−n |
| bus_addr | input | 10 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |

## Verification
The bench sweeps every input line in both trigger modes and checks the reversed bit mapping. A design that failed to mirror the index would light the wrong status bit. The bench clears status while an edge input is still high and while a level input is still active. A design that let the clear win, or that forgot to OR the level vector back in, would drop a live request. The vector is checked for every single-bit position in both scan directions and for multi-bit patterns. A design with a wrong stride, a wrong direction or no masking of the low configuration bits would return the wrong address. Writes to the read-only offsets, reads outside the window, and a second instance built without the vector unit confirm that those paths return what the register map promises.

// File: rtl/crit_intc_pkg.sv
`timescale 1ns/1ps
package crit_intc_pkg;
  localparam int REG_CNT = 9;

  typedef enum logic [3:0] {
    OFF_STAT = 4'd0,
    OFF_SET  = 4'd1,
    OFF_EN   = 4'd2,
    OFF_CRIT = 4'd3,
    OFF_POL  = 4'd4,
    OFF_TRIG = 4'd5,
    OFF_MSK  = 4'd6,
    OFF_VEC  = 4'd7,
    OFF_VCFG = 4'd8
  } reg_off_e;
endpackage

// File: rtl/crit_intc_status.sv
`timescale 1ns/1ps
// Pending-status engine: software clear/set followed by source update.
module crit_intc_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] trig_i,
  input  logic         clr_we_i,
  input  logic         set_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_d_o,
  output logic [W-1:0] status_q_o
);
  logic [W-1:0] status_q, status_d;
  logic [W-1:0] level_q, level_d;
  logic [W-1:0] prev_q;

  always_comb begin
    status_d = status_q;
    level_d  = level_q;
    if (clr_we_i) status_d = (status_d & ~wdata_i) | level_q;
    if (set_we_i) status_d = status_d | wdata_i;
    for (int b = 0; b < W; b++) begin
      if (trig_i[b]) begin
        if (src_i[b]) status_d[b] = 1'b1;
      end else if (src_i[b] != prev_q[b]) begin
        status_d[b] = src_i[b];
        level_d[b]  = src_i[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      level_q  <= '0;
      prev_q   <= '0;
    end else begin
      status_q <= status_d;
      level_q  <= level_d;
      prev_q   <= src_i;
    end
  end

  assign status_d_o = status_d;
  assign status_q_o = status_q;

  // R5: an active level source is always pending
  p_level_in_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & level_q) == level_q);

  // R3: a high edge-mode input is pending one edge later
  p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(trig_i & src_i)) == $past(trig_i & src_i)));

  // R4: a changed level-mode input is copied into status
  p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(~trig_i & (src_i ^ prev_q)) & (status_q ^ $past(src_i))) == '0));
endmodule

// File: rtl/crit_intc_vecgen.sv
`timescale 1ns/1ps
// Critical vector: base plus stride times rank of the first pending bit.
module crit_intc_vecgen #(
  parameter int W     = 32,
  parameter int SHIFT = 9
) (
  input  logic [W-1:0] crit_pend_i,
  input  logic [W-1:0] cfg_i,
  output logic [W-1:0] vec_o
);
  localparam int IW = $clog2(W);

  logic [W-1:0]  scan;
  logic [IW-1:0] idx;

  always_comb begin
    for (int k = 0; k < W; k++) begin
      scan[k] = cfg_i[0] ? crit_pend_i[W-1-k] : crit_pend_i[k];
    end
    idx = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (scan[k]) idx = IW'(k);
    end
    if (|crit_pend_i) vec_o = (cfg_i & ~W'(3)) + (W'(idx) << SHIFT);
    else              vec_o = '0;
  end
endmodule

// File: rtl/crit_intc.sv
`timescale 1ns/1ps
module crit_intc
  import crit_intc_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 10,
  parameter int unsigned BASE_ADDR = 'h30,
  parameter bit          VEC_EN    = 1'b1,
  parameter int          VEC_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_norm_o,
  output logic              irq_crit_o
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0] rel;
  logic [3:0]        off;
  logic              in_win;
  logic we_clr, we_set, we_en, we_crit, we_pol, we_trig, we_vcfg;

  assign rel    = bus_addr - BASE;
  assign off    = rel[3:0];
  assign in_win = (bus_addr >= BASE) && (rel < ADDR_W'(REG_CNT));

  assign we_clr  = bus_wr && in_win && (off == OFF_STAT);
  assign we_set  = bus_wr && in_win && (off == OFF_SET);
  assign we_en   = bus_wr && in_win && (off == OFF_EN);
  assign we_crit = bus_wr && in_win && (off == OFF_CRIT);
  assign we_pol  = bus_wr && in_win && (off == OFF_POL);
  assign we_trig = bus_wr && in_win && (off == OFF_TRIG);
  assign we_vcfg = bus_wr && in_win && (off == OFF_VCFG);

  // source n lands on status bit DATA_W-1-n
  logic [DATA_W-1:0] src_map;
  for (genvar n = 0; n < DATA_W; n++) begin : g_map
    assign src_map[DATA_W-1-n] = irq_in[n];
  end

  logic [DATA_W-1:0] en_q, crit_q, pol_q, trig_q;
  logic [DATA_W-1:0] en_d, crit_d;

  assign en_d   = we_en   ? bus_wdata : en_q;
  assign crit_d = we_crit ? bus_wdata : crit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (we_en) en_q <= bus_wdata;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crit_q <= '0;
    else if (we_crit) crit_q <= bus_wdata;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= '0;
    else if (we_pol) pol_q <= bus_wdata;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trig_q <= '0;
    else if (we_trig) trig_q <= bus_wdata;
  end

  logic [DATA_W-1:0] status_d, status_q;

  crit_intc_status #(.W(DATA_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_map),
    .trig_i     (trig_q),
    .clr_we_i   (we_clr),
    .set_we_i   (we_set),
    .wdata_i    (bus_wdata),
    .status_d_o (status_d),
    .status_q_o (status_q)
  );

  logic              norm_d;
  logic [DATA_W-1:0] critv_d;

  assign norm_d  = |(status_d & en_d & ~crit_d);
  assign critv_d = status_d & en_d & crit_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_norm_o <= 1'b0;
      irq_crit_o <= 1'b0;
    end else begin
      irq_norm_o <= norm_d;
      irq_crit_o <= |critv_d;
    end
  end

  logic [DATA_W-1:0] vcfg_rd, vec_rd;

  if (VEC_EN) begin : g_vec
    logic [DATA_W-1:0] vcfg_q, vcfg_d, vec_q, vec_d;

    assign vcfg_d = we_vcfg ? (bus_wdata & ~DATA_W'(2)) : vcfg_q;

    crit_intc_vecgen #(.W(DATA_W), .SHIFT(VEC_SHIFT)) u_vecgen (
      .crit_pend_i (critv_d),
      .cfg_i       (vcfg_d),
      .vec_o       (vec_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vcfg_q <= '0;
        vec_q  <= '0;
      end else begin
        if (we_vcfg) vcfg_q <= vcfg_d;
        vec_q <= vec_d;
      end
    end

    assign vcfg_rd = vcfg_q;
    assign vec_rd  = vec_q;

    p_vcfg_bit1_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vcfg_q[1] == 1'b0);
    p_vec_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_crit_o |-> (vec_q == '0));
    p_vec_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vec_q[1:0] == 2'b00);
  end else begin : g_novec
    assign vcfg_rd = '0;
    assign vec_rd  = '0;
  end

  always_comb begin
    bus_rdata = '0;
    if (in_win) begin
      case (off)
        OFF_STAT, OFF_SET: bus_rdata = status_q;
        OFF_EN:            bus_rdata = en_q;
        OFF_CRIT:          bus_rdata = crit_q;
        OFF_POL:           bus_rdata = pol_q;
        OFF_TRIG:          bus_rdata = trig_q;
        OFF_MSK:           bus_rdata = status_q & en_q;
        OFF_VEC:           bus_rdata = vec_rd;
        OFF_VCFG:          bus_rdata = vcfg_rd;
        default:           bus_rdata = '0;
      endcase
    end
  end

  // R6: request lines agree with the stored state
  p_norm_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm_o == |(status_q & en_q & ~crit_q));
  p_crit_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit_o == |(status_q & en_q & crit_q));
endmodule

// File: tb/crit_intc_test.sv
`timescale 1ns/1ps
module crit_intc_test;
  localparam int BASE = 'h30;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic [9:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] rdata, rdata_nv;
  logic        norm, crit, norm_nv, crit_nv;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  crit_intc uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .irq_norm_o(norm), .irq_crit_o(crit)
  );

  crit_intc #(.VEC_EN(1'b0)) uut_nv (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata_nv),
    .irq_norm_o(norm_nv), .irq_crit_o(crit_nv)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = 10'(BASE + off);
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int off, output logic [31:0] d, output logic [31:0] dnv);
    @(negedge clk);
    bus_addr = 10'(BASE + off);
    #1;
    d   = rdata;
    dnv = rdata_nv;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, dn, cfg, exp;
    rst_n = 1'b0; irq_in = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 / R2: everything reads zero after reset, also outside the window
    for (int o = 0; o < 9; o++) begin
      rd(o, d, dn);
      chk($sformatf("R10 reset reg %0d", o), d, 32'h0);
    end
    @(negedge clk);
    chk("R10 reset lines", {30'h0, norm, crit}, 32'h0);
    wr(2, 32'hFFFF_FFFF);
    rd(9, d, dn);  chk("R2 offset 9 reads 0", d, 32'h0);
    rd(-1, d, dn); chk("R2 below base reads 0", d, 32'h0);
    wr(2, 32'h0);

    // R1 / R3: every line in edge mode
    wr(5, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      @(negedge clk) irq_in = 32'h1 << n;
      @(negedge clk) irq_in = '0;
      repeat (2) @(negedge clk);
      rd(0, d, dn);
      chk($sformatf("R1 R3 edge line %0d held", n), d, 32'h1 << (31 - n));
      wr(0, 32'hFFFF_FFFF);
      rd(1, d, dn);
      chk($sformatf("R5 R7 edge line %0d cleared", n), d, 32'h0);
    end

    // R5: edge input still high wins over clear
    @(negedge clk) irq_in = 32'h8;
    wr(0, 32'hFFFF_FFFF);
    rd(0, d, dn);
    chk("R5 edge input wins over clear", d, 32'h1 << 28);
    @(negedge clk) irq_in = '0;
    wr(0, 32'hFFFF_FFFF);
    rd(0, d, dn);
    chk("R5 clear after input drops", d, 32'h0);

    // R4 / R5: every line in level mode
    wr(5, 32'h0);
    for (int n = 0; n < 32; n++) begin
      @(negedge clk) irq_in = 32'h1 << n;
      rd(0, d, dn);
      chk($sformatf("R4 level line %0d set", n), d, 32'h1 << (31 - n));
      wr(0, 32'hFFFF_FFFF);
      rd(0, d, dn);
      chk($sformatf("R5 level line %0d survives clear", n), d, 32'h1 << (31 - n));
      @(negedge clk) irq_in = '0;
      rd(0, d, dn);
      chk($sformatf("R4 level line %0d drops", n), d, 32'h0);
    end

    // R11: status-set on a quiet level source, then clear
    wr(1, 32'h0000_0C00);
    repeat (3) @(negedge clk);
    rd(0, d, dn);
    chk("R11 status-set holds", d, 32'h0000_0C00);
    wr(1, 32'h0000_0001);
    rd(0, d, dn);
    chk("R11 status-set ORs", d, 32'h0000_0C01);
    wr(0, 32'h0000_0801);
    rd(0, d, dn);
    chk("R11 partial clear", d, 32'h0000_0400);
    wr(0, 32'hFFFF_FFFF);

    // R6 / R7: line routing and masked read
    wr(2, 32'h0000_00FF);
    wr(3, 32'h0000_000F);
    wr(1, 32'h0000_0010);
    @(negedge clk);
    chk("R6 normal source", {30'h0, norm, crit}, 32'h2);
    rd(6, d, dn);
    chk("R7 masked read", d, 32'h0000_0010);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'h0000_0001);
    @(negedge clk);
    chk("R6 critical source", {30'h0, norm, crit}, 32'h1);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'h0000_0100);
    @(negedge clk);
    chk("R6 disabled source", {30'h0, norm, crit}, 32'h0);
    rd(6, d, dn);
    chk("R7 masked read of disabled", d, 32'h0);
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    rd(0, d, dn);
    chk("R7 write to masked ignored", d, 32'h0000_0100);
    rd(7, d, dn);
    chk("R7 write to vector ignored", d, 32'h0);
    wr(4, 32'hA5A5_5A5A);
    rd(4, d, dn);
    chk("R7 polarity stored", d, 32'hA5A5_5A5A);
    @(negedge clk);
    chk("R7 polarity no effect on lines", {30'h0, norm, crit}, 32'h0);
    wr(0, 32'hFFFF_FFFF);

    // R8: configuration write masks bit 1; disabled instance reads zero
    wr(8, 32'hFFFF_FFFF);
    rd(8, d, dn);
    chk("R8 bit1 forced low", d, 32'hFFFF_FFFD);
    chk("R8 no-vector config reads 0", dn, 32'h0);

    // R9: every single-bit position in both directions
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    for (int dir = 0; dir < 2; dir++) begin
      cfg = 32'h0004_2003 & ~32'h2;
      cfg[0] = dir[0];
      wr(8, cfg | 32'h2);
      for (int i = 0; i < 32; i++) begin
        wr(1, 32'h1 << i);
        exp = (cfg & ~32'h3) + 32'((dir == 1 ? (31 - i) : i) * 512);
        rd(7, d, dn);
        chk($sformatf("R9 vector dir %0d bit %0d", dir, i), d, exp);
        chk("R8 no-vector vector reads 0", dn, 32'h0);
        wr(0, 32'hFFFF_FFFF);
        rd(7, d, dn);
        chk("R9 vector idle zero", d, 32'h0);
      end
      wr(1, (32'h1 << 5) | (32'h1 << 20));
      rd(7, d, dn);
      exp = (cfg & ~32'h3) + 32'((dir == 1 ? 11 : 5) * 512);
      chk($sformatf("R9 two pending dir %0d", dir), d, exp);
      wr(0, 32'hFFFF_FFFF);
    end
    @(negedge clk);
    chk("R6 lines idle at end", {30'h0, norm, crit}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule